// File: doc/BRIEF.md
# Prioritized Exception Vector Controller

This block gathers every exception request a CPU core can receive: three reset classes, three software exceptions, two optional access-violation requests, a non-maskable external line, a maskable external line and a parameterized set of maskable device sources. It picks the single highest-ranked qualified request and returns that request's 16-bit vector address when the CPU fetches one. The three reset vectors are fixed absolute addresses. Every other vector is an 8-bit offset placed under an 8-bit vector-base register, which supplies the upper address byte.

The fixed non-maskable ranking always sits above the maskable group. Inside the maskable group, each device source carries a programmable priority level. The CPU global interrupt mask gates the whole maskable group. A separate mask gates the non-maskable line until software first clears it after reset. A fetch that finds no qualified request returns a dedicated spurious vector. This covers a request that was withdrawn between the CPU noticing it and fetching the vector. A small register port holds the vector base and the source levels.

Top module: `exc_vec_ctrl`

## Requirements
- R1: After reset, the vector base reads 0xFF, every source level reads 0, and `vec_valid_o` is low.
- R2: Reset requests outrank everything else and ignore the base. Bit 0 of `rst_req_i` (system reset) returns 0xFFFE, bit 1 (clock-monitor reset) returns 0xFFFC, and bit 2 (watchdog reset) returns 0xFFFA. When several bits are set, the lower bit wins.
- R3: Software exceptions rank below resets and above all other sources. Bit 0 of `sw_req_i` (opcode trap) returns base:0xF8, bit 1 (software interrupt / debug) returns base:0xF6, and bit 2 (system call) returns base:0x12.
- R4: The coprocessor access-violation request returns base:0x16 and outranks the CPU access-violation request, which returns base:0x14. Both outrank the external lines. The coprocessor request is ignored unless both HAS_PROT and HAS_COP are 1. The CPU request is ignored unless HAS_PROT is 1.
- R5: The non-maskable line returns base:0xF4 and outranks all maskable requests. It is ignored while `x_mask_i` is high and has never been low since reset. Once `x_mask_i` has been low, the line is honored regardless of `x_mask_i`.
- R6: The maskable external line returns base:0xF2 and outranks every device source. While `i_mask_i` is high, this line and all device sources are ignored.
- R7: Device source s returns base:(0xF0 - 2*s). A source whose level is 0 is disabled. A higher level wins. Among equal levels, the lower index (the higher offset) wins.
- R8: A one-cycle `vec_req_i` strobe updates `vec_o` on the next cycle, and `vec_valid_o` is high for exactly that cycle. Without a strobe, `vec_o` holds its value. Back-to-back strobes give back-to-back results.
- R9: A fetch that finds no qualified request returns the spurious vector base:0x10. This includes a request that was dropped before the fetch.
- R10: Register address 0 is the vector base, which forms the upper byte of every non-reset vector. Address 1+s holds the level of source s in its low 3 bits. Writes to other addresses are ignored, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | ADDR_W | Register address (0 = base, 1+s = level of source s) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| rst_req_i | input | 3 | Reset requests: system, clock monitor, watchdog |
| sw_req_i | input | 3 | Software exceptions: opcode trap, software interrupt, system call |
| cop_av_req_i | input | 1 | Coprocessor access-violation request |
| cpu_av_req_i | input | 1 | CPU access-violation request |
| nmi_req_i | input | 1 | Non-maskable external request |
| irq_req_i | input | 1 | Maskable external request |
| src_req_i | input | NUM_SRC | Maskable device source requests |
| i_mask_i | input | 1 | CPU global mask for maskable requests |
| x_mask_i | input | 1 | CPU mask for the non-maskable line until first cleared |
| vec_req_i | input | 1 | Vector fetch strobe |
| vec_o | output | 16 | Registered vector address |
| vec_valid_o | output | 1 | High for one cycle when `vec_o` holds a fresh result |

## Verification
Wrong arbitration, masking or level state shows up as a wrong vector on the cycle after the fetch strobe that exposes it. So every scenario fetches while several competing requests are held, and each fetch is matched against a queued expectation in the following cycle. Stale mask-history state or stale level state only appears when a later fetch depends on it. For that reason the sequence first checks the non-maskable line before its mask has ever cleared, then after clearing, then after the mask is set again. Register faults are visible at once on the read port and, one fetch later, in the upper vector byte.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam logic [7:0] OFF_TRAP   = 8'hF8;
  localparam logic [7:0] OFF_SWI    = 8'hF6;
  localparam logic [7:0] OFF_SYS    = 8'h12;
  localparam logic [7:0] OFF_COP_AV = 8'h16;
  localparam logic [7:0] OFF_CPU_AV = 8'h14;
  localparam logic [7:0] OFF_NMI    = 8'hF4;
  localparam logic [7:0] OFF_IRQ    = 8'hF2;
  localparam logic [7:0] OFF_SPUR   = 8'h10;
  localparam logic [7:0] OFF_SRC_HI = 8'hF0;
  localparam logic [7:0] OFF_SRC_LO = 8'h1A;

  localparam logic [15:0] VEC_RST_SYS = 16'hFFFE;
  localparam logic [15:0] VEC_RST_CLK = 16'hFFFC;
  localparam logic [15:0] VEC_RST_WDG = 16'hFFFA;

  localparam int unsigned MAX_SRC = (OFF_SRC_HI - OFF_SRC_LO) / 2 + 1;

  function automatic logic [7:0] src_off(input int unsigned idx);
    return 8'(OFF_SRC_HI - 8'(2 * idx));
  endfunction
endpackage

// File: rtl/exc_cfg_regs.sv
module exc_cfg_regs #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [7:0]                      wdata_i,
  output logic [7:0]                      rdata_o,
  output logic [7:0]                      base_o,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_o
);
  logic [7:0]                    base_q;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= 8'hFF;
      lvl_q  <= '0;
    end else if (we_i) begin
      if (addr_i == '0) base_q <= wdata_i;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (addr_i == ADDR_W'(s + 1)) lvl_q[s] <= wdata_i[LVL_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) rdata_o = base_q;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (addr_i == ADDR_W'(s + 1)) rdata_o = 8'(lvl_q[s]);
    end
  end

  assign base_o = base_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/exc_src_arb.sv
module exc_src_arb
  import exc_vec_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned LVL_W   = 3
) (
  input  logic [NUM_SRC-1:0]            req_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  input  logic                          mask_i,
  output logic                          hit_o,
  output logic [7:0]                    off_o
);
  logic [LVL_W-1:0] best_lvl;

  // scan from the top index down so the lower index takes a tie
  always_comb begin
    best_lvl = '0;
    hit_o    = 1'b0;
    off_o    = OFF_SPUR;
    for (int s = int'(NUM_SRC) - 1; s >= 0; s--) begin
      if (req_i[s] && !mask_i && (lvl_i[s] != '0) && (lvl_i[s] >= best_lvl)) begin
        best_lvl = lvl_i[s];
        hit_o    = 1'b1;
        off_o    = src_off(unsigned'(s));
      end
    end
  end
endmodule

// File: rtl/exc_fixed_sel.sv
module exc_fixed_sel
  import exc_vec_pkg::*;
#(
  parameter bit HAS_PROT = 1'b1,
  parameter bit HAS_COP  = 1'b1
) (
  input  logic [7:0]  base_i,
  input  logic [2:0]  rst_req_i,
  input  logic [2:0]  sw_req_i,
  input  logic        cop_av_i,
  input  logic        cpu_av_i,
  input  logic        nmi_i,
  input  logic        nmi_en_i,
  input  logic        irq_i,
  input  logic        irq_mask_i,
  input  logic        src_hit_i,
  input  logic [7:0]  src_off_i,
  output logic [15:0] vec_o
);
  localparam bit COP_EN = HAS_PROT && HAS_COP;

  logic cop_av, cpu_av;

  generate
    if (COP_EN) begin : g_cop
      assign cop_av = cop_av_i;
    end else begin : g_no_cop
      assign cop_av = cop_av_i & 1'b0;
    end
    if (HAS_PROT) begin : g_prot
      assign cpu_av = cpu_av_i;
    end else begin : g_no_prot
      assign cpu_av = cpu_av_i & 1'b0;
    end
  endgenerate

  always_comb begin
    if      (rst_req_i[0])            vec_o = VEC_RST_SYS;
    else if (rst_req_i[1])            vec_o = VEC_RST_CLK;
    else if (rst_req_i[2])            vec_o = VEC_RST_WDG;
    else if (sw_req_i[0])             vec_o = {base_i, OFF_TRAP};
    else if (sw_req_i[1])             vec_o = {base_i, OFF_SWI};
    else if (sw_req_i[2])             vec_o = {base_i, OFF_SYS};
    else if (cop_av)                  vec_o = {base_i, OFF_COP_AV};
    else if (cpu_av)                  vec_o = {base_i, OFF_CPU_AV};
    else if (nmi_i && nmi_en_i)       vec_o = {base_i, OFF_NMI};
    else if (irq_i && !irq_mask_i)    vec_o = {base_i, OFF_IRQ};
    else if (src_hit_i)               vec_o = {base_i, src_off_i};
    else                              vec_o = {base_i, OFF_SPUR};
  end
endmodule

// File: rtl/exc_vec_ctrl.sv
module exc_vec_ctrl
  import exc_vec_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned LVL_W    = 3,
  parameter bit          HAS_PROT = 1'b1,
  parameter bit          HAS_COP  = 1'b1,
  localparam int unsigned ADDR_W  = $clog2(NUM_SRC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  input  logic [2:0]         rst_req_i,
  input  logic [2:0]         sw_req_i,
  input  logic               cop_av_req_i,
  input  logic               cpu_av_req_i,
  input  logic               nmi_req_i,
  input  logic               irq_req_i,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic               i_mask_i,
  input  logic               x_mask_i,
  input  logic               vec_req_i,
  output logic [15:0]        vec_o,
  output logic               vec_valid_o
);
  initial begin
    if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) $error("NUM_SRC out of range");
    if (LVL_W < 1 || LVL_W > 8) $error("LVL_W out of range");
  end

  logic [7:0]                    base;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
  logic                          src_hit;
  logic [7:0]                    src_off_w;
  logic [15:0]                   sel_vec;
  logic                          x_open_q;
  logic                          nmi_en;
  logic [15:0]                   vec_q;
  logic                          valid_q;

  exc_cfg_regs #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .base_o  (base),
    .lvl_o   (lvl)
  );

  exc_src_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
    .req_i  (src_req_i),
    .lvl_i  (lvl),
    .mask_i (i_mask_i),
    .hit_o  (src_hit),
    .off_o  (src_off_w)
  );

  // non-maskable line stays gated until the X mask is first seen clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        x_open_q <= 1'b0;
    else if (!x_mask_i) x_open_q <= 1'b1;
  end
  assign nmi_en = x_open_q | ~x_mask_i;

  exc_fixed_sel #(.HAS_PROT(HAS_PROT), .HAS_COP(HAS_COP)) u_sel (
    .base_i     (base),
    .rst_req_i  (rst_req_i),
    .sw_req_i   (sw_req_i),
    .cop_av_i   (cop_av_req_i),
    .cpu_av_i   (cpu_av_req_i),
    .nmi_i      (nmi_req_i),
    .nmi_en_i   (nmi_en),
    .irq_i      (irq_req_i),
    .irq_mask_i (i_mask_i),
    .src_hit_i  (src_hit),
    .src_off_i  (src_off_w),
    .vec_o      (sel_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= vec_req_i;
      if (vec_req_i) vec_q <= sel_vec;
    end
  end

  assign vec_o       = vec_q;
  assign vec_valid_o = valid_q;
endmodule

// File: rtl/exc_vec_ctrl_chk.sv
module exc_vec_ctrl_chk #(
  parameter int unsigned NUM_SRC = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2:0]         rst_req_i,
  input logic [2:0]         sw_req_i,
  input logic               cop_av_req_i,
  input logic               cpu_av_req_i,
  input logic               nmi_req_i,
  input logic               irq_req_i,
  input logic [NUM_SRC-1:0] src_req_i,
  input logic               vec_req_i,
  input logic [7:0]         base_i,
  input logic [15:0]        vec_o,
  input logic               vec_valid_o
);
  logic any_req;
  assign any_req = (|rst_req_i) | (|sw_req_i) | cop_av_req_i | cpu_av_req_i |
                   nmi_req_i | irq_req_i | (|src_req_i);

  a_r8_valid_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_i |=> vec_valid_o);
  a_r8_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_req_i |=> !vec_valid_o);
  a_r8_vec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_req_i |=> $stable(vec_o));
  a_r2_sys_reset_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_req_i && rst_req_i[0]) |=> (vec_o == 16'hFFFE));
  a_r3_trap_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_req_i && rst_req_i == 3'b000 && sw_req_i[0]) |=> (vec_o == {$past(base_i), 8'hF8}));
  a_r9_spurious_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_req_i && !any_req) |=> (vec_o == {$past(base_i), 8'h10}));
endmodule

bind exc_vec_ctrl exc_vec_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rst_req_i    (rst_req_i),
  .sw_req_i     (sw_req_i),
  .cop_av_req_i (cop_av_req_i),
  .cpu_av_req_i (cpu_av_req_i),
  .nmi_req_i    (nmi_req_i),
  .irq_req_i    (irq_req_i),
  .src_req_i    (src_req_i),
  .vec_req_i    (vec_req_i),
  .base_i       (base),
  .vec_o        (vec_o),
  .vec_valid_o  (vec_valid_o)
);

// File: tb/exc_vec_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_vec_ctrl_tb_top;
  localparam int NSRC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata, np_rdata;
  logic [2:0]  rst_req = '0;
  logic [2:0]  sw_req = '0;
  logic        cop_av = 1'b0, cpu_av = 1'b0, nmi = 1'b0, irq = 1'b0;
  logic [NSRC-1:0] src_req = '0;
  logic        i_mask = 1'b1, x_mask = 1'b1;
  logic        vec_req = 1'b0;
  logic [15:0] vec, np_vec;
  logic        valid, np_valid;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  exc_vec_ctrl #(.NUM_SRC(NSRC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .rst_req_i(rst_req),
    .sw_req_i(sw_req), .cop_av_req_i(cop_av), .cpu_av_req_i(cpu_av),
    .nmi_req_i(nmi), .irq_req_i(irq), .src_req_i(src_req), .i_mask_i(i_mask),
    .x_mask_i(x_mask), .vec_req_i(vec_req), .vec_o(vec), .vec_valid_o(valid)
  );

  exc_vec_ctrl #(.NUM_SRC(NSRC), .HAS_PROT(1'b0), .HAS_COP(1'b1)) dut_np_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(np_rdata), .rst_req_i(rst_req),
    .sw_req_i(sw_req), .cop_av_req_i(cop_av), .cpu_av_req_i(cpu_av),
    .nmi_req_i(nmi), .irq_req_i(irq), .src_req_i(src_req), .i_mask_i(i_mask),
    .x_mask_i(x_mask), .vec_req_i(vec_req), .vec_o(np_vec), .vec_valid_o(np_valid)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected valid", vec, 16'h0000);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(vec === e, t, vec, e);
      end
    end
  end

  task automatic fetch(input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    vec_req = 1'b1;
    @(negedge clk);
    vec_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    reg_addr = a;
    #1;
    check(reg_rdata === e, t, {8'h00, reg_rdata}, {8'h00, e});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 16'h0, 16'h0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(valid === 1'b0, "R1 valid low in reset", {15'h0, valid}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'd0, 8'hFF, "R1 base reset");
    rd(4'd3, 8'h00, "R1 level reset");
    check(valid === 1'b0, "R1 valid low after reset", {15'h0, valid}, 16'h0);

    fetch(16'hFF10, "R9 spurious at reset base");

    // R10 register port
    wr(4'd0, 8'h40);
    rd(4'd0, 8'h40, "R10 base write");
    wr(4'd15, 8'h22);
    rd(4'd15, 8'h00, "R10 unmapped read");
    rd(4'd0, 8'h40, "R10 unmapped write ignored");
    fetch(16'h4010, "R10 base forms upper byte");

    // R5 nmi gated while X mask never cleared
    nmi = 1'b1;
    fetch(16'h4010, "R5 nmi gated before X cleared");
    nmi = 1'b0;

    // R7 levels
    wr(4'd2, 8'h01);
    wr(4'd3, 8'hFB);
    rd(4'd3, 8'h03, "R10 level low bits");
    wr(4'd6, 8'h03);
    i_mask = 1'b0;
    src_req = 8'b0010_0110;
    fetch(16'h40EC, "R7 tie goes to lower index");
    wr(4'd6, 8'h05);
    fetch(16'h40E6, "R7 higher level wins");
    src_req = 8'b0000_0001;
    fetch(16'h4010, "R7 level zero disabled");
    src_req = 8'b0000_0010;
    fetch(16'h40EE, "R7 single source offset");

    // R6 masking and external maskable line
    src_req = 8'b0010_0110;
    i_mask = 1'b1;
    fetch(16'h4010, "R6 I mask gates sources");
    irq = 1'b1;
    fetch(16'h4010, "R6 I mask gates irq line");
    i_mask = 1'b0;
    fetch(16'h40F2, "R6 irq line above sources");

    // R5 after X cleared once
    nmi = 1'b1;
    x_mask = 1'b0;
    @(negedge clk);
    fetch(16'h40F4, "R5 nmi with X clear");
    x_mask = 1'b1;
    @(negedge clk);
    fetch(16'h40F4, "R5 nmi stays open after X set again");

    // R4 access violations
    nmi = 1'b0; irq = 1'b0; src_req = '0;
    cop_av = 1'b1; cpu_av = 1'b1;
    fetch(16'h4016, "R4 coprocessor AV above CPU AV");
    check(np_vec === 16'h4010, "R4 AV ignored without protection", np_vec, 16'h4010);
    cop_av = 1'b0; nmi = 1'b1; irq = 1'b1;
    fetch(16'h4014, "R4 CPU AV above nmi");

    // R3 software exceptions
    cop_av = 1'b1;
    sw_req = 3'b100;
    fetch(16'h4012, "R3 system call");
    sw_req = 3'b010;
    fetch(16'h40F6, "R3 software interrupt");
    sw_req = 3'b001;
    fetch(16'h40F8, "R3 opcode trap");

    // R2 resets
    rst_req = 3'b100;
    fetch(16'hFFFA, "R2 watchdog reset");
    rst_req = 3'b110;
    fetch(16'hFFFC, "R2 clock monitor reset");
    rst_req = 3'b111;
    fetch(16'hFFFE, "R2 system reset");
    rst_req = '0; sw_req = '0; cop_av = 1'b0; cpu_av = 1'b0; nmi = 1'b0; irq = 1'b0;

    // R9 withdrawn request
    src_req = 8'b0010_0000;
    repeat (2) @(negedge clk);
    src_req = '0;
    fetch(16'h4010, "R9 withdrawn request spurious");

    // R8 back-to-back and hold
    src_req = 8'b0010_0000;
    exp_q.push_back(16'h40E6); tag_q.push_back("R8 back-to-back first");
    exp_q.push_back(16'h40E6); tag_q.push_back("R8 back-to-back second");
    vec_req = 1'b1;
    repeat (2) @(negedge clk);
    vec_req = 1'b0;
    src_req = '0;
    @(negedge clk);
    check(valid === 1'b0, "R8 valid drops", {15'h0, valid}, 16'h0);
    repeat (2) @(negedge clk);
    check(vec === 16'h40E6, "R8 vector held", vec, 16'h40E6);
    check(exp_q.size() == 0, "R8 all results seen", 16'(exp_q.size()), 16'h0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule